// File: doc/BRIEF.md
# Distributed DRAM Refresh Scheduler

This block sits in a DRAM controller and decides when auto-refresh operations happen. An interval timer counts clock cycles. Its length is the retention time divided by the number of rows, and that length is derived from parameters when the design is elaborated. Each time the timer expires, one refresh becomes owed. The block then issues a one-cycle refresh strobe together with the row address to refresh, and holds a busy signal for a fixed number of cycles. An internal row pointer moves to the next row after every refresh and wraps after the last row, so every row is refreshed once per retention period.

Owed refreshes take priority over new normal accesses. If a normal access is still in flight, the refresh waits for it to finish. Up to eight refreshes can be postponed this way. At eight, the refresh is issued whether or not an access is in flight. A temperature flag halves the interval. A mode input selects burst operation instead of distributed operation. In burst mode, once per retention period, every row is refreshed back to back, and normal accesses are then free until the next period. The block drives only a row address: no column address and no data path.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and before the first clock edge after its release, `refStrobe`, `refBusy` and `accBlock` are 0, `refRow` is 0, and `accGrant` follows `accReq`.
- R2: In distributed mode with `hotFlag` low, let L = (CLK_KHZ*RETENTION_US/1000)/ROWS. Counting clock edges after reset release as cycle 1, 2, …, and with no access in flight, `refStrobe` is high for one cycle in cycles L+1, 2L+1, 3L+1, … and low otherwise.
- R3: With `hotFlag` high, the interval of R2 becomes L/2 cycles.
- R4: The first refresh after reset carries `refRow` = 0. Each later refresh carries the previous row plus one, and row ROWS-1 is followed by row 0.
- R5: `refBusy` is high for exactly REF_CYCLES consecutive cycles, starting in the cycle of `refStrobe`.
- R6: `accBlock` is high from the cycle a refresh falls due until its busy window ends. `accGrant` equals `accReq` AND NOT `accBlock`.
- R7: While `accBusy` is high, an owed refresh is held back. The strobe comes in the cycle after `accBusy` falls, and new accesses stay blocked while the refresh waits.
- R8: Owed refreshes are counted up to 8. When 8 are owed, a refresh is issued the next cycle even if `accBusy` stays high.
- R9: With `burstMode` high, once every retention period (halved when hot) ROWS refreshes run back to back, rows 0 to ROWS-1. Their strobes are REF_CYCLES apart and `refBusy` stays high for ROWS*REF_CYCLES cycles without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hotFlag | input | 1 | Case over-temperature: halves the refresh spacing |
| burstMode | input | 1 | 1 = refresh all rows back to back once per period, 0 = distributed |
| accReq | input | 1 | Normal read/write access request |
| accBusy | input | 1 | A normal access is currently in progress |
| refStrobe | output | 1 | One-cycle pulse that starts a refresh |
| refRow | output | $clog2(ROWS) | Row address of the refresh being issued |
| refBusy | output | 1 | Memory occupied by a refresh |
| accGrant | output | 1 | Normal access request accepted this cycle |
| accBlock | output | 1 | New normal accesses are held off |

## Verification
A refresh falls due on the clock edge that ends interval n, which is cycle nL. `accBlock` rises in that same cycle. The strobe, the row and the first busy cycle appear one edge later, and busy drops REF_CYCLES edges after that. The bench counts edges from reset release and samples every output on the falling edge. It compares each cycle against closed-form expectations of these offsets, for the cool interval, the hot interval and the burst period. When it stalls a refresh, it changes `accBusy` on a falling edge and expects the strobe exactly one edge later, or at cycle 8L+1 when the postpone limit forces the refresh.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // Event from the timer datapath to the control
  typedef struct packed {
    logic tick;
  } timerEv_t;

  // Strobes from the control to the timer datapath
  typedef struct packed {
    logic issue;
  } ctrlStrobes_t;

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer
  import refsched_pkg::*;
#(
  parameter int unsigned ROWS     = 8192,
  parameter int unsigned INTERVAL = 1039,
  parameter int unsigned PERIOD   = 8512000,
  localparam int unsigned ROW_W   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hotFlag,
  input  logic             burstMode,
  input  ctrlStrobes_t     cmd,
  output timerEv_t         ev,
  output logic [ROW_W-1:0] refRow
);

  localparam int unsigned CNT_W = $clog2(PERIOD + 1);
  localparam logic [CNT_W-1:0] LAST_INT_COOL = CNT_W'(INTERVAL - 1);
  localparam logic [CNT_W-1:0] LAST_INT_HOT  = CNT_W'(INTERVAL / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_PER_COOL = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] LAST_PER_HOT  = CNT_W'(PERIOD / 2 - 1);
  localparam logic [ROW_W-1:0] ROW_LAST      = ROW_W'(ROWS - 1);

  logic [CNT_W-1:0] cycleCnt;
  logic [CNT_W-1:0] lastSel;
  logic [ROW_W-1:0] rowNext;

  always_comb begin
    if (burstMode) lastSel = hotFlag ? LAST_PER_HOT : LAST_PER_COOL;
    else           lastSel = hotFlag ? LAST_INT_HOT : LAST_INT_COOL;
    ev.tick = (cycleCnt >= lastSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN)        cycleCnt <= '0;
    else if (ev.tick) cycleCnt <= '0;
    else              cycleCnt <= cycleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowNext <= '0;
      refRow  <= '0;
    end else if (cmd.issue) begin
      refRow  <= rowNext;
      rowNext <= (rowNext == ROW_LAST) ? '0 : rowNext + 1'b1;
    end
  end

  // R2: the interval counter never runs past the longest period
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cycleCnt <= LAST_PER_COOL);

  // R4: the row output only moves on an issued refresh
  assert_row_moves_on_issue_R4: assert property (@(posedge clk) disable iff (!rstN)
    (refRow != $past(refRow)) |-> $past(cmd.issue));

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refsched_pkg::*;
#(
  parameter int unsigned ROWS         = 8192,
  parameter int unsigned REF_CYCLES   = 4,
  parameter int unsigned MAX_POSTPONE = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         burstMode,
  input  logic         accBusy,
  input  timerEv_t     ev,
  output ctrlStrobes_t cmd,
  output logic         refStrobe,
  output logic         refBusy,
  output logic         pending
);

  localparam int unsigned DEBT_W  = $clog2(MAX_POSTPONE + 1);
  localparam int unsigned BURST_W = $clog2(ROWS + 1);
  localparam int unsigned BUSY_W  = $clog2(REF_CYCLES + 1);
  localparam logic [DEBT_W-1:0]  DEBT_MAX  = DEBT_W'(MAX_POSTPONE);
  localparam logic [BURST_W-1:0] BURST_ALL = BURST_W'(ROWS);
  localparam logic [BUSY_W-1:0]  BUSY_LEN  = BUSY_W'(REF_CYCLES);

  logic [DEBT_W-1:0]  debt;
  logic [BURST_W-1:0] burstLeft;
  logic [BUSY_W-1:0]  busyLeft;
  logic forceRef, slotFree, useBurst, debtInc, debtDec;

  always_comb begin
    forceRef  = (debt == DEBT_MAX);
    useBurst  = (burstLeft != '0);
    pending   = (debt != '0) || useBurst;
    slotFree  = (busyLeft <= BUSY_W'(1));
    cmd.issue = pending && slotFree && (!accBusy || forceRef);
    debtInc   = ev.tick && !burstMode && !forceRef;
    debtDec   = cmd.issue && !useBurst;
    refBusy   = (busyLeft != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  debt <= '0;
    else if (debtInc && !debtDec) debt <= debt + 1'b1;
    else if (debtDec && !debtInc) debt <= debt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       burstLeft <= '0;
    else if (ev.tick && burstMode)   burstLeft <= BURST_ALL;
    else if (cmd.issue && useBurst)  burstLeft <= burstLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyLeft  <= '0;
      refStrobe <= 1'b0;
    end else begin
      refStrobe <= cmd.issue;
      if (cmd.issue)            busyLeft <= BUSY_LEN;
      else if (busyLeft != '0)  busyLeft <= busyLeft - 1'b1;
    end
  end

  // R5: a strobe always falls inside the busy window
  assert_strobe_in_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    refStrobe |-> refBusy);

  // R6: no strobe without an owed refresh one cycle earlier
  assert_strobe_needs_debt_R6: assert property (@(posedge clk) disable iff (!rstN)
    refStrobe |-> $past(pending));

  // R8: a full postpone count forces the refresh regardless of accBusy
  assert_force_at_limit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (forceRef && slotFree) |=> refStrobe);

  // R9: burst refreshes follow one another without a gap
  assert_burst_back_to_back_R9: assert property (@(posedge clk) disable iff (!rstN)
    (useBurst && busyLeft == BUSY_W'(1) && !accBusy) |=> refStrobe);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int unsigned CLK_KHZ      = 133000,
  parameter int unsigned RETENTION_US = 64000,
  parameter int unsigned ROWS         = 8192,
  parameter int unsigned REF_CYCLES   = 4,
  parameter int unsigned MAX_POSTPONE = 8,
  localparam int unsigned ROW_W       = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hotFlag,
  input  logic             burstMode,
  input  logic             accReq,
  input  logic             accBusy,
  output logic             refStrobe,
  output logic [ROW_W-1:0] refRow,
  output logic             refBusy,
  output logic             accGrant,
  output logic             accBlock
);

  localparam longint unsigned PERIOD_L =
    (longint'(CLK_KHZ) * longint'(RETENTION_US)) / 64'd1000;
  localparam int unsigned PERIOD   = int'(PERIOD_L);
  localparam int unsigned INTERVAL = PERIOD / ROWS;

  timerEv_t     ev;
  ctrlStrobes_t cmd;
  logic         pending;

  refresh_timer #(
    .ROWS(ROWS), .INTERVAL(INTERVAL), .PERIOD(PERIOD)
  ) uTimer (
    .clk(clk), .rstN(rstN), .hotFlag(hotFlag), .burstMode(burstMode),
    .cmd(cmd), .ev(ev), .refRow(refRow)
  );

  refresh_ctrl #(
    .ROWS(ROWS), .REF_CYCLES(REF_CYCLES), .MAX_POSTPONE(MAX_POSTPONE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .accBusy(accBusy),
    .ev(ev), .cmd(cmd), .refStrobe(refStrobe), .refBusy(refBusy),
    .pending(pending)
  );

  assign accBlock = refBusy || pending;
  assign accGrant = accReq && !accBlock;

  // R6: a granted access is never followed by a refresh start next cycle
  assert_grant_no_strobe_next_R6: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |=> !refStrobe);

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;

  localparam int ROWS = 8;
  localparam int REF  = 4;
  localparam int PER  = 256;          // 1000 kHz * 256 us
  localparam int L    = PER / ROWS;   // 32 cycles
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hotFlag = 1'b0, burstMode = 1'b0, accReq = 1'b0, accBusy = 1'b0;
  logic refStrobe, refBusy, accGrant, accBlock;
  logic [ROW_W-1:0] refRow;

  int n = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) n <= 0;
    else       n <= n + 1;
  end

  refresh_sched #(
    .CLK_KHZ(1000), .RETENTION_US(256), .ROWS(ROWS),
    .REF_CYCLES(REF), .MAX_POSTPONE(8)
  ) uut (
    .clk(clk), .rstN(rstN), .hotFlag(hotFlag), .burstMode(burstMode),
    .accReq(accReq), .accBusy(accBusy), .refStrobe(refStrobe),
    .refRow(refRow), .refBusy(refBusy), .accGrant(accGrant),
    .accBlock(accBlock)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  task automatic doReset(input logic hot, input logic burst, input logic busyIn);
    rstN = 1'b0;
    hotFlag = hot; burstMode = burst; accBusy = busyIn; accReq = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: state before the first edge after release
    chkEq("R1 strobe", int'(refStrobe), 0);
    chkEq("R1 busy", int'(refBusy), 0);
    chkEq("R1 row", int'(refRow), 0);
    chkEq("R1 block", int'(accBlock), 0);
    chkEq("R1 grant", int'(accGrant), 1);
  endtask

  // Distributed run with interval iv: strobe, row, busy and grant each cycle
  task automatic distRun(input int iv, input string tagT, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      begin
        bit expS, expB, expG;
        expS = (n > iv) && (n % iv == 1);
        expB = (n > iv) && (((n - 1) % iv) < REF);
        expG = !((n >= iv) && ((n % iv == 0) || expB));
        chkEq(tagT, int'(refStrobe), int'(expS));
        if (expS) chkEq("R4 row", int'(refRow), ((n - 1) / iv - 1) % ROWS);
        chkEq("R5 busy", int'(refBusy), int'(expB));
        chkEq("R6 grant", int'(accGrant), int'(expG));
      end
    end
  endtask

  initial begin
    // Distributed, cool: R2, R4 wrap over ten intervals
    doReset(1'b0, 1'b0, 1'b0);
    distRun(L, "R2 strobe", 10 * L + 8);

    // Distributed, hot: R3 halves the interval
    doReset(1'b1, 1'b0, 1'b0);
    distRun(L / 2, "R3 strobe", 10 * (L / 2) + 8);

    // R7: access in flight delays the due refresh
    doReset(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < L + 14; i++) begin
      @(negedge clk);
      chkEq("R7 strobe", int'(refStrobe), int'(n == L + 6));
      if (n == L + 6) chkEq("R7 row", int'(refRow), 0);
      chkEq("R7 grant", int'(accGrant), int'(!(n >= L && n <= L + 9)));
      chkEq("R7 block", int'(accBlock), int'(n >= L && n <= L + 9));
      if (n == L - 3) accBusy = 1'b1;
      if (n == L + 5) accBusy = 1'b0;
    end

    // R8: access never ends, eighth owed refresh is forced
    doReset(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 8 * L + 3; i++) begin
      @(negedge clk);
      chkEq("R8 strobe", int'(refStrobe), int'(n == 8 * L + 1));
      if (n == 8 * L + 1) chkEq("R8 row", int'(refRow), 0);
    end
    accBusy = 1'b0;

    // R9: burst mode, two full periods
    doReset(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 2 * PER + 40; i++) begin
      @(negedge clk);
      begin
        int t;
        bit expS, expB, expG;
        t = n % PER;
        expS = (n >= PER) && (t >= 1) && (t <= 1 + REF * (ROWS - 1)) && ((t - 1) % REF == 0);
        expB = (n >= PER) && (t >= 1) && (t <= REF * ROWS);
        expG = !((n >= PER) && (t <= REF * ROWS));
        chkEq("R9 strobe", int'(refStrobe), int'(expS));
        if (expS) chkEq("R9 row", int'(refRow), (t - 1) / REF);
        chkEq("R9 busy", int'(refBusy), int'(expB));
        chkEq("R9 grant", int'(accGrant), int'(expG));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule